// File: doc/BRIEF.md
# USB Transmit Prefill Release Gate

This block sits between the transmit latency FIFO fill path and the host-mode packet scheduler of a USB controller. It decides the cycle in which a waiting transmit packet may go onto the bus. The data mover pulses a strobe each time it posts one data burst into the latency FIFO, and the block counts these strobes. A packet is released only when two conditions hold: the count has reached a programmable fill threshold, and the estimated packet time plus a scheduling overhead still fits in the time left before the next Start-Of-Frame.

If the FIFO cannot reach the threshold before that time runs out, the block backs off. It raises a one-cycle back-off pulse, discards the burst count for that attempt and waits for the next frame. It also adds one to a saturating health counter that software reads to tune the overhead. The overhead is held in time units whose length depends on the link speed, and the block converts it to core-clock cycles. The frame timer supplies the time left in the frame and the packet estimate, both counted in core-clock cycles. The next frame is detected when that time-left value goes up from one cycle to the next.

A 32-bit control word holds the threshold, the health count and the overhead. Any write to it reloads the threshold and overhead fields and clears the health count. A stream-disable input makes the block ignore the programmed threshold and use the largest threshold value instead.

Top module: `usb_txfill_gate`

## Requirements
- R1: The control word reads as {10'b0, threshold[5:0], 3'b0, health[4:0], overhead[7:0]}, with the threshold in bits 21:16, the health count in bits 12:8 and the overhead in bits 7:0. It reads as all zeros after reset. A write loads the threshold from write-data bits 21:16 and the overhead from bits 7:0.
- R2: While `pkt_pend` is high and the block is armed, `pkt_start` pulses for one cycle, in the cycle after the burst count is at least the effective threshold and the time needed fits.
- R3: No packet starts while the burst count is below the effective threshold.
- R4: While `stream_off` is high, the effective threshold is 63 whatever the programmed field holds.
- R5: The time needed is `pkt_est + overhead*unit`, and it fits when it is less than or equal to `sof_left`. Equality counts as a fit.
- R6: One overhead unit is 8 core-clock cycles when `hs_link` is 1 (high speed) and 40 cycles when it is 0 (low or full speed).
- R7: While armed with `pkt_pend` high, a burst count below the threshold and a time that does not fit, the block raises `back_off` for one cycle and the health count goes up by one.
- R8: After a back-off the burst count is zero. No start and no back-off happens until a new frame is seen, which is a cycle in which `sof_left` is greater than its value in the previous cycle.
- R9: The health count saturates at 31. Back-offs still pulse `back_off` once it is there.
- R10: Any write clears the health count. When a write and a back-off fall in the same cycle, the count ends at zero.
- R11: The burst count saturates at 63 and does not wrap. For example, 66 bursts still meet a threshold of 5.
- R12: A start clears the burst count. No further decision is made until `pkt_pend` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read value |
| burst_post | input | 1 | One data burst posted to the latency FIFO |
| stream_off | input | 1 | Stream-disable mode: use the maximum threshold |
| hs_link | input | 1 | 1 = high-speed link, 0 = low/full speed |
| pkt_pend | input | 1 | A transmit packet is waiting to be scheduled |
| sof_left | input | TW | Core-clock cycles left before the next Start-Of-Frame |
| pkt_est | input | TW | Estimated packet time in core-clock cycles |
| pkt_start | output | 1 | One-cycle pulse: release the packet to the bus |
| back_off | output | 1 | One-cycle pulse: the fill deadline was missed |

## Verification
The release decision is driven with burst counts one below and at the threshold, and with the stream-disable mode on and off. These patterns separate a correct comparison from an off-by-one error and from a threshold that ignores the mode. Time-fit cases are placed exactly at, and one unit beyond, the frame boundary at both link speeds. This shows whether the overhead is added at all, whether it is scaled by the right unit, and whether equality counts as a fit. Repeated back-offs across many frames, a write landing in the same cycle as a back-off, and 66 bursts against a small threshold check three things: the health counter saturates, a write wins over an increment, and the burst count does not wrap.

// File: rtl/usb_txfill_gate.sv
module usb_txfill_gate #(
  parameter int TW      = 16,
  parameter int HS_UNIT = 8,
  parameter int FS_UNIT = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          burst_post,
  input  logic          stream_off,
  input  logic          hs_link,
  input  logic          pkt_pend,
  input  logic [TW-1:0] sof_left,
  input  logic [TW-1:0] pkt_est,
  output logic          pkt_start,
  output logic          back_off
);
  localparam int CW = 6;
  localparam int HW = 5;
  localparam int OW = 8;
  localparam int SW = TW + OW + 8;
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [HW-1:0] HMAX = '1;

  typedef enum logic [1:0] {ARM, WAIT_FRAME, WAIT_IDLE} st_t;

  st_t            st;
  logic [CW-1:0]  thr, cnt;
  logic [HW-1:0]  health;
  logic [OW-1:0]  ovh;
  logic [TW-1:0]  sof_q;

  wire            unused_bits = &{1'b0, reg_wdata[31:22], reg_wdata[15:8]};

  wire [CW-1:0]   thr_eff   = stream_off ? CMAX : thr;
  wire            fill_ok   = cnt >= thr_eff;
  wire [SW-1:0]   unit_cyc  = hs_link ? SW'(HS_UNIT) : SW'(FS_UNIT);
  wire [SW-1:0]   need_t    = SW'(pkt_est) + SW'(ovh) * unit_cyc;
  wire            fits      = need_t <= SW'(sof_left);
  wire            new_frame = sof_left > sof_q;
  wire            go        = (st == ARM) && pkt_pend && fill_ok && fits;
  wire            miss      = (st == ARM) && pkt_pend && !fill_ok && !fits;

  assign reg_rdata = {10'b0, thr, 3'b0, health, ovh};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ARM;
      thr       <= '0;
      cnt       <= '0;
      health    <= '0;
      ovh       <= '0;
      sof_q     <= '0;
      pkt_start <= 1'b0;
      back_off  <= 1'b0;
    end else begin
      sof_q     <= sof_left;
      pkt_start <= go;
      back_off  <= miss;
      if (burst_post && cnt != CMAX) cnt <= cnt + 1'b1;
      unique case (st)
        ARM: begin
          if (go) begin
            cnt <= '0;
            st  <= WAIT_IDLE;
          end else if (miss) begin
            cnt <= '0;
            st  <= WAIT_FRAME;
            if (health != HMAX) health <= health + 1'b1;
          end
        end
        WAIT_FRAME: if (new_frame) st <= ARM;
        WAIT_IDLE:  if (!pkt_pend) st <= ARM;
        default:    st <= ARM;
      endcase
      if (reg_wr) begin
        thr    <= reg_wdata[21:16];
        ovh    <= reg_wdata[7:0];
        health <= '0;
      end
    end
  end

  // R2 R3
  start_needs_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |-> $past(cnt) >= $past(thr_eff));

  // R7
  backoff_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    back_off && !$past(reg_wr) && $past(health) != HMAX |-> health == $past(health) + 1'b1);

  // R9
  health_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    health == HMAX && !reg_wr |=> health == HMAX);

  // R10
  write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> health == '0);

  // R11
  burst_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == CMAX |=> cnt == CMAX || pkt_start || back_off);

  // R8
  frame_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == WAIT_FRAME && !new_frame |=> !pkt_start && !back_off);

  // R2 R7
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |=> !pkt_start && !back_off);
endmodule

// File: tb/test_usb_txfill_gate.sv
`timescale 1ns/1ps
module test_usb_txfill_gate;
  logic        clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        burst_post = 1'b0, stream_off = 1'b0, hs_link = 1'b1, pkt_pend = 1'b0;
  logic [15:0] sof_left = '0, pkt_est = '0;
  logic        pkt_start, back_off;
  int          total = 0, bad = 0, n_start = 0, n_boff = 0;
  bit          done = 1'b0;

  usb_txfill_gate i_usb_txfill_gate (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .burst_post(burst_post), .stream_off(stream_off), .hs_link(hs_link), .pkt_pend(pkt_pend),
    .sof_left(sof_left), .pkt_est(pkt_est), .pkt_start(pkt_start), .back_off(back_off));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    #1;
    if (pkt_start) n_start++;
    if (back_off) n_boff++;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [5:0] thr, input logic [7:0] ovh);
    reg_wdata = {10'b0, thr, 3'b0, 5'b0, ovh};
    reg_wr = 1'b1;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic post(input int n);
    for (int i = 0; i < n; i++) begin
      burst_post = 1'b1;
      step(1);
    end
    burst_post = 1'b0;
  endtask

  task automatic t_reset();
    chk(reg_rdata == 32'h0, "R1 reset word", reg_rdata, 0);
    chk(n_start == 0 && n_boff == 0, "R1 no pulses in reset", n_start + n_boff, 0);
  endtask

  task automatic t_regmap();
    reg_wdata = 32'hFFFF_FFFF;
    reg_wr = 1'b1;
    step(1);
    reg_wr = 1'b0;
    chk(reg_rdata == 32'h003F_00FF, "R1 field layout", reg_rdata, 32'h003F_00FF);
    write_reg(6'h2A, 8'hC5);
    chk(reg_rdata == 32'h002A_00C5, "R1 field values", reg_rdata, 32'h002A_00C5);
  endtask

  task automatic t_fill();
    int s0;
    write_reg(6'd4, 8'd0);
    sof_left = 16'd1000; pkt_est = 16'd100; hs_link = 1'b1;
    step(2);
    s0 = n_start;
    pkt_pend = 1'b1;
    post(3);
    step(3);
    chk(n_start == s0, "R3 below threshold", n_start - s0, 0);
    post(1);
    step(2);
    chk(n_start == s0 + 1, "R2 start at threshold", n_start - s0, 1);
    step(3);
    chk(n_start == s0 + 1, "R12 no repeat while pending", n_start - s0, 1);
    pkt_pend = 1'b0;
    step(2);
    pkt_pend = 1'b1;
    step(3);
    chk(n_start == s0 + 1, "R12 count cleared at start", n_start - s0, 1);
    post(4);
    step(2);
    chk(n_start == s0 + 2, "R12 rearmed after pend low", n_start - s0, 2);
    pkt_pend = 1'b0;
    step(2);
  endtask

  task automatic t_stream();
    int s0 = n_start;
    write_reg(6'd2, 8'd0);
    stream_off = 1'b1;
    pkt_pend = 1'b1;
    post(10);
    step(3);
    chk(n_start == s0, "R4 programmed threshold ignored", n_start - s0, 0);
    post(52);
    step(3);
    chk(n_start == s0, "R4 62 bursts not enough", n_start - s0, 0);
    post(1);
    step(2);
    chk(n_start == s0 + 1, "R4 start at 63", n_start - s0, 1);
    pkt_pend = 1'b0; stream_off = 1'b0;
    step(2);
  endtask

  task automatic t_overhead();
    int s0 = n_start;
    write_reg(6'd0, 8'd7);
    sof_left = 16'd150; pkt_est = 16'd100; hs_link = 1'b1;
    pkt_pend = 1'b1;
    step(4);
    chk(n_start == s0, "R5 overhead pushes past frame", n_start - s0, 0);
    write_reg(6'd0, 8'd6);
    step(2);
    chk(n_start == s0 + 1, "R5 smaller overhead fits", n_start - s0, 1);
    pkt_pend = 1'b0;
    step(2);
  endtask

  task automatic t_speed();
    int s0 = n_start;
    write_reg(6'd0, 8'd10);
    sof_left = 16'd300; pkt_est = 16'd100; hs_link = 1'b1;
    pkt_pend = 1'b1;
    step(3);
    chk(n_start == s0 + 1, "R6 high-speed unit fits", n_start - s0, 1);
    pkt_pend = 1'b0;
    step(2);
    hs_link = 1'b0;
    pkt_pend = 1'b1;
    step(4);
    chk(n_start == s0 + 1, "R6 full-speed unit too long", n_start - s0, 1);
    write_reg(6'd0, 8'd5);
    step(2);
    chk(n_start == s0 + 2, "R5 exact fit at boundary", n_start - s0, 2);
    pkt_pend = 1'b0; hs_link = 1'b1;
    step(2);
  endtask

  task automatic t_backoff();
    int s0 = n_start, b0 = n_boff;
    write_reg(6'd4, 8'd0);
    pkt_est = 16'd100; sof_left = 16'd90;
    post(2);
    pkt_pend = 1'b1;
    step(2);
    chk(n_boff == b0 + 1, "R7 back-off pulse", n_boff - b0, 1);
    chk(reg_rdata[12:8] == 5'd1, "R7 health incremented", reg_rdata[12:8], 1);
    step(2);
    chk(n_boff == b0 + 1, "R8 single back-off per frame", n_boff - b0, 1);
    post(2);
    pkt_est = 16'd10; sof_left = 16'd80;
    step(5);
    chk(n_start == s0, "R8 no start before new frame", n_start - s0, 0);
    sof_left = 16'd500;
    step(4);
    chk(n_start == s0, "R8 count cleared by back-off", n_start - s0, 0);
    post(2);
    step(2);
    chk(n_start == s0 + 1, "R8 start after new frame", n_start - s0, 1);
    pkt_pend = 1'b0;
    step(2);
  endtask

  task automatic one_backoff();
    pkt_est = 16'd100; sof_left = 16'd90;
    pkt_pend = 1'b1;
    step(2);
    pkt_pend = 1'b0; sof_left = 16'd500;
    step(2);
  endtask

  task automatic t_sat();
    int b0;
    write_reg(6'd4, 8'd0);
    b0 = n_boff;
    for (int i = 0; i < 31; i++) one_backoff();
    chk(reg_rdata[12:8] == 5'd31, "R9 reaches 31", reg_rdata[12:8], 31);
    for (int i = 0; i < 4; i++) one_backoff();
    chk(reg_rdata[12:8] == 5'd31, "R9 holds at 31", reg_rdata[12:8], 31);
    chk(n_boff == b0 + 35, "R9 back-offs continue", n_boff - b0, 35);
  endtask

  task automatic t_write_prio();
    int b0;
    write_reg(6'd4, 8'd0);
    chk(reg_rdata[12:8] == 5'd0, "R10 write clears", reg_rdata[12:8], 0);
    one_backoff();
    chk(reg_rdata[12:8] == 5'd1, "R10 count before clash", reg_rdata[12:8], 1);
    b0 = n_boff;
    pkt_est = 16'd100; sof_left = 16'd90;
    reg_wdata = {10'b0, 6'd4, 16'd0};
    reg_wr = 1'b1; pkt_pend = 1'b1;
    step(1);
    reg_wr = 1'b0;
    step(1);
    chk(n_boff == b0 + 1, "R10 back-off in write cycle", n_boff - b0, 1);
    chk(reg_rdata[12:8] == 5'd0, "R10 write wins", reg_rdata[12:8], 0);
    pkt_pend = 1'b0; sof_left = 16'd1000;
    step(2);
  endtask

  task automatic t_burst_sat();
    int s0 = n_start;
    write_reg(6'd5, 8'd0);
    pkt_est = 16'd100; sof_left = 16'd1200;
    post(66);
    pkt_pend = 1'b1;
    step(2);
    chk(n_start == s0 + 1, "R11 count saturates", n_start - s0, 1);
    pkt_pend = 1'b0;
    step(2);
  endtask

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_regmap();
    t_fill();
    t_stream();
    t_overhead();
    t_speed();
    t_backoff();
    t_sat();
    t_write_prio();
    t_burst_sat();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule